// File: doc/BRIEF.md
# Cycle-indexed instruction sequencer core

A small 8-bit processor core that moves forward by exactly one bus cycle on every clock. In each cycle it either reads or writes one byte of an external memory. It drives a 16-bit address, a data output byte and a read/write strobe that is high for a read. It also raises a one-cycle marker whenever the cycle on the bus is an opcode fetch. The memory must answer a read in the same cycle. Its byte is taken in on the next rising clock edge.

All decoding works from one 11-bit state register. The opcode sits in its upper eight bits and a cycle index sits in its low three. The register steps by one on every clock, and the combined value picks what the current cycle does. The last cycle of each instruction already puts out the fetch of the next opcode, so fetch and execute overlap. When the core sees its fetch marker high at an edge, the incoming byte replaces the opcode and the cycle index restarts at zero. The instruction subset is small: load immediate, store absolute, jump absolute and a no-operation. Opcode zero re-runs the start sequence.

Top module: `cyc_core`

## Requirements
- R1: While rst_n is low, the outputs are rd=1, sync=0, addr=0x0000 and acc=0x00, with flag_z=1 and flag_n=0.
- R2: The decoder state holds the opcode in bits 10:3 and a cycle index in bits 2:0. The whole value increases by one per clock. Outside a fetch cycle the index never reaches 7.
- R3: The last cycle of every instruction drives the program counter on addr with sync=1 and rd=1, and the counter then advances by one. sync is high for exactly one cycle.
- R4: The byte on data_in at the edge that closes a sync cycle becomes the next opcode. rd is high on every cycle except the single write cycle of a store.
- R5: After reset, and whenever opcode 0x00 runs, a 7-cycle start sequence runs. It reads the low start byte at 0xFFFC, then the high byte at 0xFFFD. The next fetch is from the address those two bytes form, and acc and the flags are unchanged.
- R6: Opcode 0xA9 (load immediate) takes 2 cycles. acc takes the operand byte, flag_z is set when that byte is zero, and flag_n copies its bit 7.
- R7: Opcode 0x8D (store absolute) takes 4 cycles. It reads the low and then the high address byte, then makes one write cycle with rd=0 at that address and acc on data_out. The flags are unchanged.
- R8: Opcode 0x4C (jump absolute) takes 3 cycles. It reads the low and then the high target byte, and the next fetch is from the target.
- R9: Opcode 0xEA, and every opcode other than 0x00, 0x4C, 0x8D and 0xA9, takes 2 cycles. Such an opcode changes neither acc, the flags nor memory, and the next fetch is from the following byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bus cycle per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| data_in | input | 8 | Byte read from memory at addr in the current cycle |
| addr | output | 16 | Bus address of the current cycle |
| data_out | output | 8 | Byte to be written when rd is low |
| rd | output | 1 | High for a read cycle, low for a write cycle |
| sync | output | 1 | High while the current cycle fetches an opcode |
| acc | output | 8 | Accumulator |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |

## Verification
One program runs from the reset vector. It loads the operands 0x33, 0x00 and 0x80, which separate the plain, zero and negative flag results. It then stores to two different addresses, so that the address bytes and the written data cannot be swapped or go stale. A no-operation, a jump to another page, an unlisted opcode and a restart through opcode 0x00 follow. Between two fetch markers the bench counts the cycles and checks the address of the fetch. This tells apart each instruction's length, the order in which it reads its operand bytes, and whether it leaves the accumulator, the flags and memory untouched.

// File: rtl/cyc_core.sv
module cyc_core (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  data_in,
  output logic [15:0] addr,
  output logic [7:0]  data_out,
  output logic        rd,
  output logic        sync,
  output logic [7:0]  acc,
  output logic        flag_n,
  output logic        flag_z
);
  localparam logic [7:0]  OP_RESTART = 8'h00;
  localparam logic [7:0]  OP_LDI     = 8'hA9;
  localparam logic [7:0]  OP_STA     = 8'h8D;
  localparam logic [7:0]  OP_JMP     = 8'h4C;
  localparam logic [15:0] VEC_LO     = 16'hFFFC;
  localparam logic [15:0] VEC_HI     = 16'hFFFD;

  logic [10:0] ir, cur, nx_ir;
  logic [15:0] pc, nx_pc, nx_addr, tgt;
  logic [7:0]  lo, nx_lo, nx_acc, nx_dout;
  logic        nx_rd, nx_sync, nx_n, nx_z, fetch;
  logic [7:0]  op;
  logic [2:0]  cnt;

  assign cur = sync ? {data_in, 3'd0} : ir;
  assign op  = cur[10:3];
  assign cnt = cur[2:0];

  always_comb begin
    nx_ir   = cur + 11'd1;
    nx_pc   = pc;
    nx_addr = addr;
    nx_lo   = lo;
    nx_acc  = acc;
    nx_dout = data_out;
    nx_n    = flag_n;
    nx_z    = flag_z;
    nx_rd   = 1'b1;
    fetch   = 1'b0;
    tgt     = pc;
    case (op)
      OP_RESTART:
        case (cnt)
          3'd0, 3'd1, 3'd2, 3'd3: nx_addr = pc;
          3'd4: nx_addr = VEC_LO;
          3'd5: begin nx_lo = data_in; nx_addr = VEC_HI; end
          default: begin fetch = 1'b1; tgt = {data_in, lo}; end
        endcase
      OP_LDI:
        case (cnt)
          3'd0: begin nx_addr = pc; nx_pc = pc + 16'd1; end
          default: begin
            nx_acc = data_in;
            nx_z   = (data_in == 8'd0);
            nx_n   = data_in[7];
            fetch  = 1'b1;
          end
        endcase
      OP_STA:
        case (cnt)
          3'd0: begin nx_addr = pc; nx_pc = pc + 16'd1; end
          3'd1: begin nx_lo = data_in; nx_addr = pc; nx_pc = pc + 16'd1; end
          3'd2: begin nx_addr = {data_in, lo}; nx_rd = 1'b0; nx_dout = acc; end
          default: fetch = 1'b1;
        endcase
      OP_JMP:
        case (cnt)
          3'd0: begin nx_addr = pc; nx_pc = pc + 16'd1; end
          3'd1: begin nx_lo = data_in; nx_addr = pc; nx_pc = pc + 16'd1; end
          default: begin fetch = 1'b1; tgt = {data_in, lo}; end
        endcase
      default:
        case (cnt)
          3'd0: nx_addr = pc;
          default: fetch = 1'b1;
        endcase
    endcase
    if (fetch) begin
      nx_addr = tgt;
      nx_pc   = tgt + 16'd1;
    end
    nx_sync = fetch;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ir       <= {OP_RESTART, 3'd0};
      pc       <= 16'd0;
      addr     <= 16'd0;
      lo       <= 8'd0;
      acc      <= 8'd0;
      data_out <= 8'd0;
      flag_n   <= 1'b0;
      flag_z   <= 1'b1;
      rd       <= 1'b1;
      sync     <= 1'b0;
    end else begin
      ir       <= nx_ir;
      pc       <= nx_pc;
      addr     <= nx_addr;
      lo       <= nx_lo;
      acc      <= nx_acc;
      data_out <= nx_dout;
      flag_n   <= nx_n;
      flag_z   <= nx_z;
      rd       <= nx_rd;
      sync     <= nx_sync;
    end
  end
endmodule

// File: rtl/cyc_core_chk.sv
module cyc_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [10:0] ir,
  input logic        rd,
  input logic        sync,
  input logic [7:0]  data_out,
  input logic [7:0]  acc
);
  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) !sync |-> ir[2:0] != 3'd7); // R2
  AST_SYNC_READ: assert property (@(posedge clk) disable iff (!rst_n) sync |-> rd); // R3
  AST_SYNC_PULSE: assert property (@(posedge clk) disable iff (!rst_n) sync |=> !sync); // R3
  AST_WRITE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) !rd |=> rd); // R4
  AST_WRITE_DATA: assert property (@(posedge clk) disable iff (!rst_n) !rd |-> data_out == acc); // R7
endmodule

bind cyc_core cyc_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ir(ir), .rd(rd), .sync(sync),
  .data_out(data_out), .acc(acc)
);

// File: tb/tb_cyc_core.sv
module tb_cyc_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  data_in;
  logic [15:0] addr;
  logic [7:0]  data_out;
  logic        rd, sync;
  logic [7:0]  acc;
  logic        flag_n, flag_z;

  int checks = 0;
  int fails = 0;
  int wr_n = 0;
  int wa = 0;
  int wd = 0;

  logic [7:0] mem [0:4095];

  always #4 clk = ~clk;

  cyc_core dut (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .addr(addr),
    .data_out(data_out), .rd(rd), .sync(sync), .acc(acc),
    .flag_n(flag_n), .flag_z(flag_z)
  );

  assign data_in = mem[addr[11:0]];

  always @(posedge clk) if (rst_n && !rd) mem[addr[11:0]] <= data_out;

  always @(negedge clk) if (rst_n && !rd) begin
    wr_n = wr_n + 1;
    wa = int'(addr);
    wd = int'(data_out);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic next_sync(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sync && n < 40);
    if (!sync) check(1'b0, "watchdog", n, 0);
  endtask

  task automatic run_instr(input string req, input int cyc, input int nxt);
    int n;
    next_sync(n);
    check(n == cyc, {req, " cycles"}, n, cyc);
    check(int'(addr) == nxt, {req, " fetch address"}, int'(addr), nxt);
    check(rd == 1'b1, {req, " fetch reads"}, int'(rd), 1);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(rd == 1'b1 && sync == 1'b0, "R1 rd/sync", {rd, sync}, 2);
    check(addr == 16'h0000, "R1 addr", int'(addr), 0);
    check(acc == 8'h00 && flag_z && !flag_n, "R1 acc/flags", {acc, flag_n, flag_z}, 1);
    rst_n = 1'b1;
  endtask

  task automatic t_start;
    int n;
    next_sync(n);
    check(n == 7, "R5 start length", n, 7);
    check(addr == 16'h0200, "R5 vector fetch", int'(addr), 'h200);
  endtask

  task automatic t_loads;
    run_instr("R6 ldi 33", 2, 'h202);
    check(acc == 8'h33 && !flag_z && !flag_n, "R6 value 33", {acc, flag_n, flag_z}, 'h33 << 2);
    run_instr("R6 ldi 00", 2, 'h204);
    check(acc == 8'h00 && flag_z && !flag_n, "R6 zero flag", {acc, flag_n, flag_z}, 1);
    run_instr("R6 ldi 80", 2, 'h206);
    check(acc == 8'h80 && !flag_z && flag_n, "R6 negative flag", {acc, flag_n, flag_z}, ('h80 << 2) | 2);
  endtask

  task automatic t_store(input int at, input int ta, input int val);
    int w0;
    w0 = wr_n;
    run_instr("R7 store", 4, at + 3);
    check(wr_n == w0 + 1, "R7 one write cycle R4", wr_n - w0, 1);
    check(wa == ta, "R7 write address", wa, ta);
    check(wd == val, "R7 write data", wd, val);
    check(int'(mem[ta[11:0]]) == val, "R7 memory content", int'(mem[ta[11:0]]), val);
    check(acc == val[7:0] && flag_n == val[7], "R7 flags kept", {acc, flag_n}, {val[7:0], val[7]});
  endtask

  task automatic t_nop_jump;
    int w0;
    w0 = wr_n;
    run_instr("R9 nop", 2, 'h20A);
    check(acc == 8'h80 && flag_n && !flag_z && wr_n == w0, "R9 nop no effect", {acc, flag_n, flag_z}, ('h80 << 2) | 2);
    run_instr("R8 jump", 3, 'h500);
    run_instr("R6 ldi 5a", 2, 'h502);
    check(acc == 8'h5A, "R6 value 5a", int'(acc), 'h5A);
  endtask

  task automatic t_unknown;
    int w0;
    w0 = wr_n;
    run_instr("R9 unlisted opcode", 2, 'h506);
    check(acc == 8'h5A && !flag_n && !flag_z && wr_n == w0, "R9 unlisted no effect", {acc, flag_n, flag_z}, 'h5A << 2);
  endtask

  task automatic t_restart;
    run_instr("R5 opcode 00 restart", 7, 'h200);
    check(acc == 8'h5A, "R5 acc kept", int'(acc), 'h5A);
    run_instr("R2 R4 opcode after restart", 2, 'h202);
    check(acc == 8'h33, "R4 new opcode latched", int'(acc), 'h33);
  endtask

  initial begin
    #100us;
    check(1'b0, "watchdog timeout", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    mem['hFFC] = 8'h00; mem['hFFD] = 8'h02;
    mem['h200] = 8'hA9; mem['h201] = 8'h33;
    mem['h202] = 8'hA9; mem['h203] = 8'h00;
    mem['h204] = 8'hA9; mem['h205] = 8'h80;
    mem['h206] = 8'h8D; mem['h207] = 8'h40; mem['h208] = 8'h03;
    mem['h209] = 8'hEA;
    mem['h20A] = 8'h4C; mem['h20B] = 8'h00; mem['h20C] = 8'h05;
    mem['h500] = 8'hA9; mem['h501] = 8'h5A;
    mem['h502] = 8'h8D; mem['h503] = 8'h41; mem['h504] = 8'h03;
    mem['h505] = 8'h02;
    mem['h506] = 8'h00;
    t_reset;
    t_start;
    t_loads;
    t_store('h206, 'h340, 'h80);
    t_nop_jump;
    t_store('h502, 'h341, 'h5A);
    t_unknown;
    t_restart;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule